// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Access Master

This block runs complete command frames on a three-wire serial EEPROM bus (select, shift clock, serial data toward the memory, serial data back from it) to read one 16-bit word, to arm the memory for writing, or to write one word. A request carries an operation, a word address, write data and an address-width flag. The width flag chooses 6 or 8 address bits for that request alone. The shift clock is derived from the system clock by a divider value that is supplied at run time.

A single write request performs the whole write sequence. The block first sends an enable frame and drops select. It then raises select again and sends the write frame with its data. After that it drops select once more and polls the memory's data line until the memory reports ready. The poll is bounded: if the memory never reports ready, the access ends with an error flag. Every access ends with select low. A one-cycle done pulse marks the end of the access, and a read delivers its word alongside that pulse.

Top module: `uwire_eeprom_ctrl`

## Requirements
- R1: Every frame begins with a start bit of 1, then a 2-bit opcode, then the address MSB first. The opcodes are read = 10, write = 01 and write-enable = 00. The write-enable frame carries an address whose two most significant bits are 11 and whose other bits are 0.
- R2: When `wide` = 1 the frame carries 8 address bits taken from `addr[7:0]`. When `wide` = 0 it carries 6 bits taken from `addr[5:0]`, and `addr[7:6]` are ignored. The enable address is 8'hC0 with 8 bits and 6'h30 with 6 bits.
- R3: `ee_di` takes its bit value before `ee_sk` rises and holds it for the whole high phase.
- R4: Operation codes 2'b00 and 2'b11 perform a read. After the read command, 16 further clock periods shift data in MSB first, sampling `ee_do` at the end of each high phase. The word appears on `rdata` together with `done`.
- R5: Operation 2'b10 writes. It sends a write-enable frame, lowers then raises `ee_cs`, and then sends a write frame followed by the 16 bits of `wdata`, MSB first. Operation 2'b01 sends only the write-enable frame.
- R6: Within a write, `ee_cs` stays low for at least CS_GAP clock cycles between the two frames and again after the data. Select is then raised and `ee_do` is polled. The access completes without error as soon as `ee_do` is found high.
- R7: The poll makes at most POLL_TRIES checks, spaced POLL_GAP+1 cycles apart. If `ee_do` is never high, `err` is asserted in the same cycle as `done`.
- R8: `ee_cs` is low whenever the block is idle, so it is low at the end of every access. `ee_sk` is high only while `ee_cs` is high.
- R9: `busy` is high from the cycle after a request is accepted until `done`. A `req` seen while `busy` is high starts nothing.
- R10: `done` is high for exactly one cycle per access.
- R11: Each low phase and each high phase of `ee_sk` lasts `clk_div`+1 clock cycles.
- R12: During reset, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_div | input | DIV_W | Shift clock phase length minus one, in clock cycles |
| req | input | 1 | Start an access (taken only while idle) |
| op | input | 2 | 00/11 read, 01 write-enable, 10 write |
| addr | input | 8 | Word address |
| wdata | input | 16 | Word to write |
| wide | input | 1 | 1 = 8 address bits, 0 = 6 address bits |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| err | output | 1 | Ready poll exhausted, valid with done |
| rdata | output | 16 | Word returned by the last read |
| ee_cs | output | 1 | Memory select |
| ee_sk | output | 1 | Shift clock |
| ee_di | output | 1 | Serial data toward the memory |
| ee_do | input | 1 | Serial data and ready status from the memory |

## Verification
The assertions assume that `ee_do` is synchronous to `clk` and that `clk_div` does not change while `busy` is high. If either assumption fails, the phase lengths and the point at which read data are sampled lose their meaning. The bench's memory model therefore changes `ee_do` only on falling clock edges, after it has seen a shift clock edge. The bench also changes `clk_div` only between accesses. Requests raised during an access are issued on purpose, to check that they are ignored.

// File: rtl/uwire_pkg.sv
`timescale 1ns/1ps
package uwire_pkg;
   localparam int WORD_W  = 16;
   localparam int ADDR_W  = 8;
   localparam int FRAME_W = 3 + ADDR_W + WORD_W;
   localparam int LEN_W   = $clog2(FRAME_W + 1);

   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] OPC_EWEN  = 2'b00;

   localparam logic [1:0] REQ_WREN  = 2'b01;
   localparam logic [1:0] REQ_WRITE = 2'b10;

   typedef enum logic [3:0] {
      ST_IDLE, ST_RD, ST_EN, ST_GAP1, ST_WR, ST_GAP2, ST_POLL, ST_PWAIT, ST_END
   } seq_e;

   // Left-aligned frame: start bit, opcode, address, data.
   function automatic logic [FRAME_W-1:0] mk_frame(input logic [1:0] opc,
                                                   input logic [ADDR_W-1:0] adr,
                                                   input logic wide,
                                                   input logic [WORD_W-1:0] dat);
      if (wide) return {1'b1, opc, adr, dat};
      else      return {1'b1, opc, adr[5:0], dat, 2'b00};
   endfunction

   function automatic logic [LEN_W-1:0] frame_len(input logic wide, input logic has_data);
      logic [LEN_W-1:0] n;
      n = wide ? LEN_W'(3 + 8) : LEN_W'(3 + 6);
      if (has_data) n = n + LEN_W'(WORD_W);
      return n;
   endfunction

   function automatic logic [ADDR_W-1:0] ewen_addr(input logic wide);
      return wide ? 8'hC0 : 8'h30;
   endfunction
endpackage

// File: rtl/uwire_tick.sv
`timescale 1ns/1ps
module uwire_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!en)        cnt <= '0;
      else if (cnt == div) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   assign tick = en && (cnt == div);
endmodule

// File: rtl/uwire_shifter.sv
`timescale 1ns/1ps
module uwire_shifter
   import uwire_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] vec,
   input  logic [LEN_W-1:0]   len,
   input  logic               tick,
   input  logic               ser_in,
   output logic               active,
   output logic               sk,
   output logic               ser_out,
   output logic [WORD_W-1:0]  rx,
   output logic               fin
);
   logic [FRAME_W-1:0] sr;
   logic [LEN_W-1:0]   left;
   logic               hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr <= '0; left <= '0; hi <= 1'b0; active <= 1'b0; rx <= '0; fin <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (start) begin
            sr     <= vec;
            left   <= len;
            active <= 1'b1;
            hi     <= 1'b0;
         end else if (active && tick) begin
            if (!hi) begin
               hi <= 1'b1;
            end else begin
               hi   <= 1'b0;
               sr   <= sr << 1;
               rx   <= {rx[WORD_W-2:0], ser_in};
               left <= left - 1'b1;
               if (left == LEN_W'(1)) begin
                  active <= 1'b0;
                  fin    <= 1'b1;
               end
            end
         end
      end
   end

   assign sk      = hi;
   assign ser_out = active & sr[FRAME_W-1];
endmodule

// File: rtl/uwire_eeprom_ctrl.sv
`timescale 1ns/1ps
module uwire_eeprom_ctrl
   import uwire_pkg::*;
#(
   parameter int DIV_W      = 8,
   parameter int CS_GAP     = 50,
   parameter int POLL_GAP   = 2000000,
   parameter int POLL_TRIES = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  clk_div,
   input  logic              req,
   input  logic [1:0]        op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wdata,
   input  logic              wide,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [WORD_W-1:0] rdata,
   output logic              ee_cs,
   output logic              ee_sk,
   output logic              ee_di,
   input  logic              ee_do
);
   localparam int WAIT_MAX = (POLL_GAP > CS_GAP) ? POLL_GAP : CS_GAP;
   localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
   localparam int TRY_W    = $clog2(POLL_TRIES + 1);
   localparam logic [WAIT_W-1:0] GAP_LAST  = WAIT_W'(CS_GAP - 1);
   localparam logic [WAIT_W-1:0] POLL_LAST = WAIT_W'(POLL_GAP - 1);
   localparam logic [TRY_W-1:0]  TRY_LAST  = TRY_W'(POLL_TRIES - 1);

   generate
      if (CS_GAP < 1 || POLL_GAP < 1 || POLL_TRIES < 1) begin : g_bad_timing
         $error("uwire_eeprom_ctrl: CS_GAP, POLL_GAP and POLL_TRIES must be at least 1");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("uwire_eeprom_ctrl: DIV_W must be at least 1");
      end
   endgenerate

   seq_e               st;
   logic [1:0]         op_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [WORD_W-1:0]  wd_q;
   logic               wide_q, fail;
   logic [WAIT_W-1:0]  wcnt;
   logic [TRY_W-1:0]   tries;
   logic               sh_start, sh_active, sh_fin, tick;
   logic [FRAME_W-1:0] sh_vec;
   logic [LEN_W-1:0]   sh_len;
   logic [WORD_W-1:0]  sh_rx;

   uwire_tick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(sh_active), .div(clk_div), .tick(tick)
   );

   uwire_shifter u_shift (
      .clk(clk), .rst_n(rst_n), .start(sh_start), .vec(sh_vec), .len(sh_len),
      .tick(tick), .ser_in(ee_do), .active(sh_active), .sk(ee_sk),
      .ser_out(ee_di), .rx(sh_rx), .fin(sh_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; op_q <= '0; addr_q <= '0; wd_q <= '0; wide_q <= 1'b0;
         fail <= 1'b0; wcnt <= '0; tries <= '0; sh_start <= 1'b0; sh_vec <= '0;
         sh_len <= '0; rdata <= '0; ee_cs <= 1'b0; done <= 1'b0; err <= 1'b0;
      end else begin
         sh_start <= 1'b0;
         done     <= 1'b0;
         err      <= 1'b0;
         unique case (st)
            ST_IDLE: if (req) begin
               op_q <= op; addr_q <= addr; wd_q <= wdata; wide_q <= wide;
               fail <= 1'b0; ee_cs <= 1'b1; sh_start <= 1'b1;
               if (op == REQ_WREN || op == REQ_WRITE) begin
                  sh_vec <= mk_frame(OPC_EWEN, ewen_addr(wide), wide, '0);
                  sh_len <= frame_len(wide, 1'b0);
                  st     <= ST_EN;
               end else begin
                  sh_vec <= mk_frame(OPC_READ, addr, wide, '0);
                  sh_len <= frame_len(wide, 1'b1);
                  st     <= ST_RD;
               end
            end
            ST_RD: if (sh_fin) begin
               rdata <= sh_rx;
               st    <= ST_END;
            end
            ST_EN: if (sh_fin) begin
               if (op_q == REQ_WRITE) begin
                  ee_cs <= 1'b0; wcnt <= '0; st <= ST_GAP1;
               end else begin
                  st <= ST_END;
               end
            end
            ST_GAP1: if (wcnt == GAP_LAST) begin
               ee_cs    <= 1'b1;
               sh_start <= 1'b1;
               sh_vec   <= mk_frame(OPC_WRITE, addr_q, wide_q, wd_q);
               sh_len   <= frame_len(wide_q, 1'b1);
               st       <= ST_WR;
            end else wcnt <= wcnt + 1'b1;
            ST_WR: if (sh_fin) begin
               ee_cs <= 1'b0; wcnt <= '0; st <= ST_GAP2;
            end
            ST_GAP2: if (wcnt == GAP_LAST) begin
               ee_cs <= 1'b1; tries <= '0; st <= ST_POLL;
            end else wcnt <= wcnt + 1'b1;
            ST_POLL: if (ee_do) begin
               st <= ST_END;
            end else if (tries == TRY_LAST) begin
               fail <= 1'b1; st <= ST_END;
            end else begin
               tries <= tries + 1'b1; wcnt <= '0; st <= ST_PWAIT;
            end
            ST_PWAIT: if (wcnt == POLL_LAST) st <= ST_POLL;
                      else wcnt <= wcnt + 1'b1;
            ST_END: begin
               ee_cs <= 1'b0; done <= 1'b1; err <= fail; st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy = (st != ST_IDLE);

   // Checker state: consecutive cycles with select low, saturating.
   logic [WAIT_W-1:0] cs_low_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cs_low_run <= '0;
      else if (ee_cs)                    cs_low_run <= '0;
      else if (cs_low_run != WAIT_W'(CS_GAP)) cs_low_run <= cs_low_run + 1'b1;
   end

   AST_DI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ee_sk && $past(ee_sk) |-> $stable(ee_di)); // R3
   AST_DI_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ee_sk) |-> $stable(ee_di)); // R3
   AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ee_cs) && $past(busy) |-> cs_low_run >= WAIT_W'(CS_GAP)); // R6
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done); // R7
   AST_CS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ee_cs); // R8
   AST_SK_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      ee_sk |-> ee_cs); // R8
   AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      busy && req |=> $stable(addr_q) && $stable(op_q)); // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10
endmodule

// File: tb/sim_uwire_eeprom_ctrl.sv
`timescale 1ns/1ps
module sim_uwire_eeprom_ctrl;
   localparam int DIV_W = 8, CS_GAP = 4, POLL_GAP = 20, POLL_TRIES = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [DIV_W-1:0] clk_div = '0;
   logic req = 1'b0, wide = 1'b1;
   logic [1:0] op = '0;
   logic [7:0] addr = '0;
   logic [15:0] wdata = '0, rdata;
   logic busy, done, err, ee_cs, ee_sk, ee_di, ee_do;

   always #2.5 clk = ~clk;

   uwire_eeprom_ctrl #(.DIV_W(DIV_W), .CS_GAP(CS_GAP), .POLL_GAP(POLL_GAP),
                       .POLL_TRIES(POLL_TRIES)) u0 (
      .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .req(req), .op(op), .addr(addr),
      .wdata(wdata), .wide(wide), .busy(busy), .done(done), .err(err), .rdata(rdata),
      .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
   );

   int n_chk = 0, n_fail = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
      end
   endtask

   // ---------------- behavioural memory model ----------------
   logic [15:0] mem [256];
   logic [31:0] m_sh = '0;
   logic [15:0] m_rdat = '0;
   logic [1:0]  m_opc = '0;
   logic [7:0]  m_addr = '0;
   logic m_do = 1'b0, m_wen = 1'b0, cs_q = 1'b0, sk_q = 1'b0, di_rise = 1'b0;
   logic mdl_wide = 1'b1, busy_clear = 1'b0, in_acc = 1'b0;
   int m_n = 0, m_busy = 0, busy_set = 0, commit_cyc = 0, nfr = 0, di_bad = 0;
   int lowrun = 0, gap_min = 0, t_rise = 0, per_last = 0;
   int log_start [8], log_opc [8], log_addr [8];

   assign ee_do = (m_n == 0) ? (m_busy == 0) : m_do;

   always @(negedge clk) begin
      int aw, cl;
      aw = mdl_wide ? 8 : 6;
      cl = 3 + aw;
      if (busy_clear) m_busy = 0;
      else if (m_busy > 0) m_busy = m_busy - 1;
      if (!ee_cs) begin
         if (cs_q) begin
            if (m_n == cl + 16 && m_opc == 2'b01 && m_wen) begin
               mem[m_addr] = m_sh[15:0];
               m_busy = busy_set;
               commit_cyc = cyc;
               m_wen = 1'b0;
            end
            m_n = 0;
            m_do = 1'b0;
            lowrun = 1;
         end else lowrun = lowrun + 1;
      end else begin
         if (!cs_q && in_acc && nfr > 0 && lowrun < gap_min) gap_min = lowrun;
         if (ee_sk && !sk_q) begin
            m_sh = {m_sh[30:0], ee_di};
            m_n = m_n + 1;
            di_rise = ee_di;
            per_last = cyc - t_rise;
            t_rise = cyc;
            if (m_n == cl) begin
               m_opc  = m_sh[aw +: 2];
               m_addr = mdl_wide ? m_sh[7:0] : {2'b00, m_sh[5:0]};
               log_start[nfr % 8] = int'(m_sh[aw + 2]);
               log_opc[nfr % 8]   = int'(m_opc);
               log_addr[nfr % 8]  = int'(m_addr);
               nfr = nfr + 1;
               if (m_opc == 2'b00 && m_addr[aw-1 -: 2] == 2'b11) m_wen = 1'b1;
               if (m_opc == 2'b10) m_rdat = mem[m_addr];
            end
         end else if (ee_sk && sk_q) begin
            if (ee_di != di_rise) di_bad = di_bad + 1;
         end else if (!ee_sk && sk_q) begin
            if (m_opc == 2'b10 && m_n >= cl && m_n < cl + 16) m_do = m_rdat[15 - (m_n - cl)];
         end
      end
      cs_q = ee_cs;
      sk_q = ee_sk;
   end

   // ---------------- access helpers ----------------
   int t0 = 0, t_done = 0;
   logic [15:0] got_rdata;
   logic got_err;

   task automatic issue(input logic [1:0] o, input logic [7:0] a, input logic [15:0] d,
                        input logic w);
      @(negedge clk);
      mdl_wide = w; nfr = 0; gap_min = 1000000; in_acc = 1'b1; t0 = cyc;
      op = o; addr = a; wdata = d; wide = w; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic wait_done(input string rq);
      bit seen = 0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (done) begin seen = 1; break; end
      end
      chk(seen, rq, "done seen", seen, 1);
      t_done = cyc; got_rdata = rdata; got_err = err; in_acc = 1'b0;
      chk(!ee_cs && !busy, "R8", "select low and idle at done", {ee_cs, busy}, 0);
      @(negedge clk);
      chk(!done, "R10", "done lasts one cycle", done, 0);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk({ee_cs, ee_sk, ee_di, busy, done, err} == 6'b0, "R12", "outputs in reset",
          {ee_cs, ee_sk, ee_di, busy, done, err}, 0);
   endtask

   task automatic t_read_wide();
      mem[8'hA5] = 16'hC3A1;
      issue(2'b00, 8'hA5, 16'h0, 1'b1);
      wait_done("R4");
      chk(got_rdata == 16'hC3A1, "R4", "read word 8-bit addr", got_rdata, 16'hC3A1);
      chk(nfr == 1 && log_start[0] == 1 && log_opc[0] == 2, "R1", "read frame start/opcode",
          log_opc[0], 2);
      chk(log_addr[0] == 8'hA5, "R2", "8-bit address field", log_addr[0], 8'hA5);
      chk(got_err == 1'b0, "R7", "no error on read", got_err, 0);
   endtask

   task automatic t_read_narrow();
      mem[8'h2B] = 16'h5A0F;
      mem[8'hEB] = 16'h1111;
      issue(2'b11, 8'hEB, 16'h0, 1'b0);
      wait_done("R2");
      chk(log_addr[0] == 8'h2B, "R2", "6-bit address drops upper bits", log_addr[0], 8'h2B);
      chk(got_rdata == 16'h5A0F, "R4", "read word 6-bit addr, op 11", got_rdata, 16'h5A0F);
   endtask

   task automatic t_period(input int div);
      @(negedge clk); clk_div = DIV_W'(div);
      mem[8'h07] = 16'h0F0F;
      issue(2'b00, 8'h07, 16'h0, 1'b1);
      wait_done("R11");
      chk(per_last == 2 * (div + 1), "R11", "shift clock period", per_last, 2 * (div + 1));
      chk(got_rdata == 16'h0F0F, "R4", "read with divided clock", got_rdata, 16'h0F0F);
      chk(di_bad == 0, "R3", "data held through high phase", di_bad, 0);
      @(negedge clk); clk_div = '0;
   endtask

   task automatic t_ewen();
      m_wen = 1'b0;
      issue(2'b01, 8'h00, 16'h0, 1'b1);
      wait_done("R5");
      chk(nfr == 1 && log_opc[0] == 0, "R5", "enable-only single frame", nfr, 1);
      chk(log_addr[0] == 8'hC0, "R1", "enable address bits 11", log_addr[0], 8'hC0);
      chk(m_wen == 1'b1, "R1", "memory armed by enable frame", m_wen, 1);
      m_wen = 1'b0;
   endtask

   task automatic t_write(input logic [7:0] a, input logic [15:0] d, input logic w);
      busy_set = 30;
      issue(2'b10, a, d, w);
      wait_done("R6");
      chk(nfr == 2 && log_opc[0] == 0 && log_opc[1] == 1, "R5", "enable then write frames",
          {log_opc[0], log_opc[1]}, 1);
      chk(log_addr[0] == (w ? 8'hC0 : 8'h30), "R2", "enable address for width",
          log_addr[0], w ? 8'hC0 : 8'h30);
      chk(log_addr[1] == (w ? a : {2'b00, a[5:0]}), "R5", "write address", log_addr[1], a);
      chk(mem[w ? a : {2'b00, a[5:0]}] == d, "R5", "word stored",
          mem[w ? a : {2'b00, a[5:0]}], d);
      chk(gap_min >= CS_GAP, "R6", "select low gap length", gap_min, CS_GAP);
      chk(t_done - commit_cyc >= 30, "R6", "done waits for ready", t_done - commit_cyc, 30);
      chk(got_err == 1'b0, "R6", "no error when ready", got_err, 0);
   endtask

   task automatic t_timeout();
      busy_set = 1000000;
      issue(2'b10, 8'h44, 16'hA5A5, 1'b1);
      wait_done("R7");
      chk(got_err == 1'b1, "R7", "error after exhausted poll", got_err, 1);
      chk(t_done - t0 >= (POLL_TRIES - 1) * (POLL_GAP + 1), "R7", "poll duration",
          t_done - t0, (POLL_TRIES - 1) * (POLL_GAP + 1));
      @(negedge clk); busy_clear = 1'b1;
      @(negedge clk); busy_clear = 1'b0;
   endtask

   task automatic t_busy_ignore();
      bit was_busy;
      mem[8'h11] = 16'h1234;
      issue(2'b00, 8'h11, 16'h0, 1'b1);
      repeat (5) @(negedge clk);
      was_busy = busy;
      op = 2'b10; addr = 8'h22; wdata = 16'hDEAD; req = 1'b1;
      @(negedge clk); req = 1'b0;
      wait_done("R9");
      chk(was_busy, "R9", "busy during access", was_busy, 1);
      chk(got_rdata == 16'h1234, "R9", "first request result kept", got_rdata, 16'h1234);
      repeat (50) @(negedge clk);
      chk(nfr == 1 && !busy && !ee_cs, "R9", "request while busy started nothing", nfr, 1);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101) ^ 16'h5555;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_read_wide();
      t_read_narrow();
      t_period(3);
      t_period(0);
      t_ewen();
      t_write(8'h3C, 16'hBEEF, 1'b1);
      t_write(8'hD5, 16'h0F0F, 1'b0);
      t_timeout();
      t_busy_ignore();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule